// File: doc/BRIEF.md
# ADC Conversion Command Sequencer

This block sits between the 2-wire slave logic and an external analog-to-digital converter. The host first writes a command byte to the converter's device identifier. That byte selects the conversion type and, where it matters, a channel. From then on, every result byte the host clocks out of the read path causes one conversion. The block starts the conversion, waits for the converter to report completion, captures the sample, and tags it with the channel it came from.

Four conversion types are supported:

- a fixed single channel;
- a repeating scan over the lower four channels;
- a repeating scan over all eight channels;
- a differential measurement of an upper channel against its paired over-current sense input.

In the scan types, the channel pointer advances after each finished conversion and wraps back to the start. A STOP from the host ends the read sequence. The next read then begins again at the first channel of the group.

The converter is represented only by its handshake: a start pulse out, and a done pulse with data back in. The block also drives the multiplexer select and a flag that puts the converter in differential mode.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset, conv_start, rd_valid, mux_sel and diff_mode are all 0. The mode is single-channel on channel 0, so reads without any command convert channel 0 only.
- R2: Command byte layout: bits 7:5 hold the command code, bits 2:0 hold the channel, and bits 4:3 must be 0. Code 000 selects single-channel mode on the given channel. Every read in this mode converts that channel, and mux_sel equals it one cycle after the write.
- R3: Code 001 selects the short scan. Successive conversions use channels 0, 1, 2, 3 and then wrap to 0. The write itself resets the pointer to 0.
- R4: Code 011 selects the full scan. Successive conversions use channels 0 through 7 and then wrap to 0.
- R5: Code 100 with channel 4 to 7 selects differential mode. diff_mode is 1, and mux_sel holds the named channel for every conversion.
- R6: A command is rejected if it is differential with a channel below 4, uses any other code (010, 101, 110, 111), or has bits 4:3 nonzero. After a rejected command, mode, channel pointer, mux_sel and diff_mode are all unchanged.
- R7: A rd_req while idle produces a conv_start pulse exactly one cycle wide, one cycle later. A rd_req while a conversion is outstanding is dropped and not queued. No new start is issued before the done pulse of the previous one.
- R8: When conv_done arrives during a conversion, rd_data takes conv_data, rd_ch takes the converted channel, and rd_valid pulses for one cycle, all one cycle after the done. The channel pointer advances at the same edge, and mux_sel stays stable while a conversion is outstanding.
- R9: rd_stop while idle returns the pointer to the group's first channel. rd_stop while a conversion is outstanding, including in the same cycle as its done, still delivers that result, and then returns the pointer to the first channel instead of advancing.
- R10: A command write while a conversion is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: command byte written to the converter identifier |
| cmd_byte | input | 8 | Command byte (code, reserved bits, channel) |
| rd_req | input | 1 | One-cycle strobe: host clocks out a result byte |
| rd_stop | input | 1 | One-cycle strobe: STOP ends the read sequence |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_data | input | 8 | Converter sample, valid with conv_done |
| conv_start | output | 1 | One-cycle pulse starting a conversion |
| mux_sel | output | 3 | Analog multiplexer channel select |
| diff_mode | output | 1 | Converter measures channel against its over-current input |
| rd_valid | output | 1 | One-cycle pulse: new result available |
| rd_data | output | 8 | Latched conversion result |
| rd_ch | output | 3 | Channel the latched result came from |

## Verification
Two events can meet in one cycle: a STOP and the converter's done pulse. In that case the pointer must go back to the group start rather than advance, and the finishing result must still be delivered. The bench raises rd_stop in exactly the cycle it raises conv_done. It also raises rd_stop one cycle earlier, while the conversion is outstanding. In both cases it checks that rd_ch names the converted channel and that mux_sel afterwards shows channel 0. A command write and a second read request are likewise placed inside an outstanding conversion, and both are judged at the ports.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_ONE   = 2'd0,
    MODE_SCAN4 = 2'd1,
    MODE_SCAN8 = 2'd2,
    MODE_DIFF  = 2'd3
  } seq_mode_t;

  localparam logic [2:0] CODE_ONE   = 3'b000;
  localparam logic [2:0] CODE_SCAN4 = 3'b001;
  localparam logic [2:0] CODE_SCAN8 = 3'b011;
  localparam logic [2:0] CODE_DIFF  = 3'b100;
endpackage

// File: rtl/adc_cmd_dec.sv
module adc_cmd_dec
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_byte,
  input  logic            accept_en,
  output logic            load,
  output seq_mode_t       ld_mode,
  output logic [CH_W-1:0] ld_base,
  output seq_mode_t       mode,
  output logic [CH_W-1:0] base
);
  logic [2:0]      code;
  logic [CH_W-1:0] ch_f;
  logic            legal;
  seq_mode_t       mode_q;
  logic [CH_W-1:0] base_q;

  always_comb begin
    code    = cmd_byte[7:5];
    ch_f    = cmd_byte[CH_W-1:0];
    ld_mode = MODE_ONE;
    legal   = 1'b0;
    case (code)
      CODE_ONE:   begin ld_mode = MODE_ONE;   legal = 1'b1; end
      CODE_SCAN4: begin ld_mode = MODE_SCAN4; legal = 1'b1; end
      CODE_SCAN8: begin ld_mode = MODE_SCAN8; legal = 1'b1; end
      CODE_DIFF:  begin ld_mode = MODE_DIFF;  legal = ch_f[CH_W-1]; end
      default:    begin ld_mode = MODE_ONE;   legal = 1'b0; end
    endcase
    if (cmd_byte[4:CH_W] != '0) legal = 1'b0;
    ld_base = ch_f;
    load    = cmd_valid & accept_en & legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ONE;
      base_q <= '0;
    end else if (load) begin
      mode_q <= ld_mode;
      base_q <= ld_base;
    end
  end

  assign mode = mode_q;
  assign base = base_q;
endmodule

// File: rtl/adc_ch_ptr.sv
module adc_ch_ptr
  import adc_seq_pkg::*;
#(
  parameter int CH_W       = 3,
  parameter int SCAN_SHORT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_mode_t       mode,
  input  logic [CH_W-1:0] base,
  input  logic            load,
  input  seq_mode_t       ld_mode,
  input  logic [CH_W-1:0] ld_base,
  input  logic            stop,
  input  logic            busy,
  input  logic            adv,
  output logic [CH_W-1:0] cur_ch
);
  localparam int NUM_CH = 1 << CH_W;

  logic [CH_W-1:0] ch_q, ch_nxt;
  logic            pend_q, pend_nxt;

  function automatic logic [CH_W-1:0] first_of(seq_mode_t m, logic [CH_W-1:0] b);
    return (m == MODE_ONE || m == MODE_DIFF) ? b : '0;
  endfunction

  function automatic logic [CH_W-1:0] last_of(seq_mode_t m, logic [CH_W-1:0] b);
    case (m)
      MODE_SCAN4: return CH_W'(SCAN_SHORT - 1);
      MODE_SCAN8: return CH_W'(NUM_CH - 1);
      default:    return b;
    endcase
  endfunction

  always_comb begin
    ch_nxt   = ch_q;
    pend_nxt = pend_q;
    if (load) begin
      ch_nxt   = first_of(ld_mode, ld_base);
      pend_nxt = 1'b0;
    end else if (adv) begin
      if (stop || pend_q || ch_q == last_of(mode, base))
        ch_nxt = first_of(mode, base);
      else
        ch_nxt = ch_q + 1'b1;
      pend_nxt = 1'b0;
    end else if (stop) begin
      if (busy) pend_nxt = 1'b1;
      else      ch_nxt   = first_of(mode, base);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      ch_q   <= ch_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign cur_ch = ch_q;
endmodule

// File: rtl/adc_conv_hs.sv
module adc_conv_hs #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CH_W-1:0]   cur_ch,
  output logic              conv_start,
  output logic              busy,
  output logic              adv,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_W-1:0]   rd_ch
);
  logic              busy_q, busy_nxt;
  logic              start_q, go;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic [CH_W-1:0]   tag_q;

  always_comb begin
    go       = rd_req & ~busy_q;
    adv      = conv_done & busy_q;
    busy_nxt = go | (busy_q & ~adv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_nxt;
      start_q <= go;
      valid_q <= adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tag_q  <= '0;
    end else if (adv) begin
      data_q <= conv_data;
      tag_q  <= cur_ch;
    end
  end

  assign conv_start = start_q;
  assign busy       = busy_q;
  assign rd_valid   = valid_q;
  assign rd_data    = data_q;
  assign rd_ch      = tag_q;
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W       = 3,
  parameter int DATA_W     = 8,
  parameter int SCAN_SHORT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic              rd_req,
  input  logic              rd_stop,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   mux_sel,
  output logic              diff_mode,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_W-1:0]   rd_ch
);
  seq_mode_t       mode, ld_mode;
  logic [CH_W-1:0] base, ld_base, cur_ch;
  logic            load, busy, adv;

  adc_cmd_dec #(.CH_W(CH_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .accept_en(~busy), .load(load), .ld_mode(ld_mode), .ld_base(ld_base),
    .mode(mode), .base(base)
  );

  adc_ch_ptr #(.CH_W(CH_W), .SCAN_SHORT(SCAN_SHORT)) ptr_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .base(base), .load(load),
    .ld_mode(ld_mode), .ld_base(ld_base), .stop(rd_stop), .busy(busy),
    .adv(adv), .cur_ch(cur_ch)
  );

  adc_conv_hs #(.CH_W(CH_W), .DATA_W(DATA_W)) hs_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .conv_done(conv_done),
    .conv_data(conv_data), .cur_ch(cur_ch), .conv_start(conv_start),
    .busy(busy), .adv(adv), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ch(rd_ch)
  );

  assign mux_sel   = cur_ch;
  assign diff_mode = (mode == MODE_DIFF);
endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [CH_W-1:0]   mux_sel,
  input logic              diff_mode
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          open_q <= 1'b0;
    else if (conv_start) open_q <= 1'b1;
    else if (conv_done)  open_q <= 1'b0;
  end

  a_r7_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r7_no_start_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> !conv_start);

  a_r8_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && open_q) |=> rd_valid);

  a_r8_data_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && open_q) |=> (rd_data == $past(conv_data)));

  a_r8_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> $stable(mux_sel));

  a_r5_diff_upper: assert property (@(posedge clk) disable iff (!rst_n)
    diff_mode |-> mux_sel[CH_W-1]);
endmodule

bind adc_cmd_seq adc_cmd_seq_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .conv_data(conv_data), .rd_valid(rd_valid), .rd_data(rd_data),
  .mux_sel(mux_sel), .diff_mode(diff_mode)
);

// File: tb/adc_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module adc_cmd_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       rd_req = 1'b0;
  logic       rd_stop = 1'b0;
  logic       conv_done = 1'b0;
  logic [7:0] conv_data = '0;
  logic       conv_start;
  logic [2:0] mux_sel;
  logic       diff_mode;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [2:0] rd_ch;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  adc_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rd_req(rd_req), .rd_stop(rd_stop), .conv_done(conv_done),
    .conv_data(conv_data), .conv_start(conv_start), .mux_sel(mux_sel),
    .diff_mode(diff_mode), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ch(rd_ch)
  );

  // cmd[14:7], first channel [6:4], last channel [3:1], diff [0]
  localparam logic [14:0] VEC [0:7] = '{
    {8'h05, 3'd5, 3'd5, 1'b0},   // R2 single ch5
    {8'h20, 3'd0, 3'd3, 1'b0},   // R3 short scan
    {8'h60, 3'd0, 3'd7, 1'b0},   // R4 full scan
    {8'h86, 3'd6, 3'd6, 1'b1},   // R5 differential ch6
    {8'h82, 3'd6, 3'd6, 1'b1},   // R6 diff on ch2 rejected
    {8'h40, 3'd6, 3'd6, 1'b1},   // R6 code 010 rejected
    {8'h8D, 3'd6, 3'd6, 1'b1},   // R6 reserved bits set rejected
    {8'h01, 3'd1, 3'd1, 1'b0}    // R2 single ch1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  // stop_at: 0 none, 1 while outstanding, 2 together with done
  task automatic do_read(input logic [7:0] d, input logic [2:0] exp_ch,
                         input int stop_at, input string tag);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk({tag, " R7 start"}, conv_start, 1);
    chk({tag, " R8 sel"}, mux_sel, exp_ch);
    if (stop_at == 1) rd_stop = 1'b1;
    @(negedge clk);
    rd_stop = (stop_at == 2);
    chk({tag, " R7 start width"}, conv_start, 0);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk); conv_done = 1'b0; rd_stop = 1'b0;
    chk({tag, " R8 valid"}, rd_valid, 1);
    chk({tag, " R8 data"}, rd_data, d);
    chk({tag, " R8 tag"}, rd_ch, exp_ch);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 mux_sel", mux_sel, 0);
    chk("R1 diff_mode", diff_mode, 0);
    do_read(8'h11, 3'd0, 0, "R1 read a");
    do_read(8'h12, 3'd0, 0, "R1 read b");

    for (int i = 0; i < 8; i++) begin
      logic [2:0] f, l;
      f = VEC[i][6:4];
      l = VEC[i][3:1];
      write_cmd(VEC[i][14:7]);
      chk("R2-6 table sel", mux_sel, f);
      chk("R5-6 table diff", diff_mode, VEC[i][0]);
      for (int k = 0; k < 9; k++) begin
        logic [2:0] e;
        e = f + 3'(k % (int'(l) - int'(f) + 1));
        do_read(8'(i * 16 + k + 1), e, 0, "R2-6 table");
        chk("R5 diff held", diff_mode, VEC[i][0]);
      end
    end

    // R7: request during outstanding conversion is dropped
    write_cmd(8'h60);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk("R7 first start", conv_start, 1);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk("R7 no start while busy", conv_start, 0);
    @(negedge clk);
    chk("R7 still no start", conv_start, 0);
    conv_done = 1'b1; conv_data = 8'hA5;
    @(negedge clk); conv_done = 1'b0;
    chk("R7 one result", rd_ch, 0);
    @(negedge clk);
    chk("R7 not queued", conv_start, 0);
    chk("R7 single valid", rd_valid, 0);
    @(negedge clk);
    chk("R7 not queued later", conv_start, 0);

    // R10: command write while busy ignored (scan8 pointer at 1)
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    cmd_valid = 1'b1; cmd_byte = 8'h86;
    @(negedge clk); cmd_valid = 1'b0;
    conv_done = 1'b1; conv_data = 8'h3C;
    @(negedge clk); conv_done = 1'b0;
    chk("R10 tag", rd_ch, 1);
    chk("R10 diff unchanged", diff_mode, 0);
    chk("R10 scan continues", mux_sel, 2);

    // R9: STOP handling
    write_cmd(8'h60);
    do_read(8'h21, 3'd0, 0, "R9 a");
    do_read(8'h22, 3'd1, 0, "R9 b");
    @(negedge clk); rd_stop = 1'b1;
    @(negedge clk); rd_stop = 1'b0;
    chk("R9 idle stop restart", mux_sel, 0);
    do_read(8'h23, 3'd0, 0, "R9 c");
    do_read(8'h24, 3'd1, 1, "R9 stop during conversion");
    chk("R9 restart after pending stop", mux_sel, 0);
    do_read(8'h25, 3'd0, 0, "R9 d");
    do_read(8'h26, 3'd1, 2, "R9 stop with done");
    chk("R9 restart on coincident stop", mux_sel, 0);
    do_read(8'h27, 3'd0, 0, "R9 e");
    do_read(8'h28, 3'd1, 0, "R9 f");
    chk("R4 resumes stepping", mux_sel, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule